// File: doc/BRIEF.md
# Ordered Store Buffer with In-Queue Fences

This block is a small queue that holds stores between the point where a core retires them and the write port of a level-one data cache. Each queue slot holds a regular store, a non-temporal (weakly ordered) store, or a fence marker. Two fence markers exist: a full fence and a store-only fence. A fence does not empty the queue when it enters. It takes a slot like any store, and it orders only what the queue lets pass it.

The queue always tries to empty itself. On each cycle it offers the oldest entry that may legally leave to the cache port. A non-temporal store that has retired may overtake older stores that are still speculative, unless a fence lies between them. The same block also answers load queries, and a load is taken to be younger than every entry in the queue. A query reports whether the load may issue now, which is not the case while a full fence is queued. It also returns forwarded data from the youngest matching regular store. A pipeline flush kills the entries that have no retire mark. Those entries then leave through the head one per cycle, with no write.

Top module: `store_fence_buffer`

## Requirements
- R1: The queue holds DEPTH (8) entries. `alloc_ready` is low while all 8 slots are occupied or while `flush` is high, and a held `alloc_valid` is not accepted in that time. `alloc_tag` gives the slot index used for that entry's later retire mark.
- R2: A store is offered on the cache port only after its slot has received a retire mark (`retire_valid` with `retire_tag`).
- R3: Regular stores are written to the cache in allocation order. Each cycle the queue offers its oldest eligible entry, whether or not a fence is queued behind it.
- R4: While a full fence (`alloc_kind` 2'b10) is in the queue, `lq_grant` is 0. It returns to 1 in the cycle after the fence has left the head of the queue.
- R5: A non-temporal store (`alloc_kind` 2'b01) allocated after a store-only fence (`alloc_kind` 2'b11) is not written before the regular stores (`alloc_kind` 2'b00) allocated before that fence.
- R6: With no fence between them, a retired non-temporal store may be written before an older regular store that has not yet retired.
- R7: Store-only fences and buffered regular stores leave `lq_grant` at 1.
- R8: A retired fence at the head leaves the queue in one cycle and causes no cache write.
- R9: A load query hits when a live regular store matches `lq_addr` exactly and no full fence lies between that store and the load. `lq_data` then carries the data of the youngest such store. Non-temporal stores never forward.
- R10: A `flush` kills every entry that has no retire mark, and that entry is never written or forwarded. Entries that have already retired, fences included, keep their effect.
- R11: After reset the queue is empty: `alloc_ready`=1, `cm_valid`=0, `lq_grant`=1, `lq_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request to add an entry |
| alloc_kind | input | 2 | 00 regular store, 01 non-temporal store, 10 full fence, 11 store-only fence |
| alloc_addr | input | AW | Store address |
| alloc_data | input | DW | Store data |
| alloc_ready | output | 1 | Entry is accepted this cycle when high |
| alloc_tag | output | log2(DEPTH) | Slot index the entry takes |
| retire_valid | input | 1 | Retire mark for one slot |
| retire_tag | input | log2(DEPTH) | Slot that retires |
| flush | input | 1 | Kill all entries without a retire mark |
| cm_valid | output | 1 | A store is offered to the cache |
| cm_ready | input | 1 | Cache takes the offered store |
| cm_tag | output | log2(DEPTH) | Slot of the offered store |
| cm_addr | output | AW | Offered store address |
| cm_data | output | DW | Offered store data |
| cm_nt | output | 1 | Offered store is non-temporal |
| lq_addr | input | AW | Load query address |
| lq_grant | output | 1 | The load may issue now |
| lq_hit | output | 1 | Forwarded data is valid |
| lq_data | output | DW | Forwarded data |

## Verification
Some properties are checked on every cycle. No store reaches the cache port without a retire mark. A full queue refuses allocation. A newly allocated full fence removes load permission on the next cycle. A fence leaving the head never coincides with a cache write. A retired regular store at the head is always offered. Other behaviour shows only in the bench's scenarios: the order of writes relative to fences, a non-temporal store overtaking a speculative one, youngest-match forwarding cut off by a full fence, and flush killing speculative entries while retired fences keep blocking loads.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    K_ST   = 2'b00,
    K_NT   = 2'b01,
    K_FULL = 2'b10,
    K_SFEN = 2'b11
  } sb_kind_e;

  function automatic logic is_fence(sb_kind_e k);
    return k[1];
  endfunction

  function automatic logic is_store(sb_kind_e k);
    return !k[1];
  endfunction

endpackage

// File: rtl/sb_entries.sv
module sb_entries
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IW-1:0]   push_slot,
  input  sb_kind_e        push_kind,
  input  logic [AW-1:0]   push_addr,
  input  logic [DW-1:0]   push_data,
  input  logic            ret_valid,
  input  logic [IW-1:0]   ret_slot,
  input  logic            flush,
  input  logic            done_set,
  input  logic [IW-1:0]   done_slot,
  input  logic            pop,
  input  logic [IW-1:0]   pop_slot,
  output logic [DEPTH-1:0] live,
  output logic [DEPTH-1:0] retired,
  output logic [DEPTH-1:0] done,
  output sb_kind_e        kind [DEPTH],
  output logic [AW-1:0]   addr [DEPTH],
  output logic [DW-1:0]   data [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic ret_hit;
    assign ret_hit = ret_valid && (ret_slot == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live[i]    <= 1'b0;
        retired[i] <= 1'b0;
        done[i]    <= 1'b0;
      end else if (push && push_slot == IW'(i)) begin
        live[i]    <= 1'b1;
        retired[i] <= 1'b0;
        done[i]    <= 1'b0;
      end else if (pop && pop_slot == IW'(i)) begin
        live[i]    <= 1'b0;
      end else if (live[i]) begin
        if (ret_hit) retired[i] <= 1'b1;
        if (flush && !retired[i] && !ret_hit) done[i] <= 1'b1;
        if (done_set && done_slot == IW'(i)) done[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push && push_slot == IW'(i)) begin
        kind[i] <= push_kind;
        addr[i] <= push_addr;
        data[i] <= push_data;
      end
    end
  end

endmodule

// File: rtl/sb_commit_sel.sv
module sb_commit_sel
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] live,
  input  logic [DEPTH-1:0] retired,
  input  logic [DEPTH-1:0] done,
  input  sb_kind_e         kind [DEPTH],
  input  logic [AW-1:0]    addr [DEPTH],
  input  logic [DW-1:0]    data [DEPTH],
  output logic             sel_valid,
  output logic [IW-1:0]    sel_slot,
  output logic [AW-1:0]    sel_addr,
  output logic [DW-1:0]    sel_data,
  output logic             sel_nt,
  output logic             sel_is_head
);

  logic [IW-1:0] age_slot [DEPTH];
  logic          older_pend;
  logic          fence_pend;
  logic          elig;

  // Walk from oldest to youngest; a regular store needs every older entry
  // gone, a non-temporal store needs only that no fence precedes it.
  always_comb begin
    sel_valid  = 1'b0;
    sel_slot   = head;
    older_pend = 1'b0;
    fence_pend = 1'b0;
    elig       = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      age_slot[k] = head + IW'(k);
      if (live[age_slot[k]] && !done[age_slot[k]]) begin
        elig = retired[age_slot[k]] &&
               ((kind[age_slot[k]] == K_ST && !older_pend) ||
                (kind[age_slot[k]] == K_NT && !fence_pend));
        if (elig && !sel_valid) begin
          sel_valid = 1'b1;
          sel_slot  = age_slot[k];
        end
        older_pend = 1'b1;
        if (is_fence(kind[age_slot[k]])) fence_pend = 1'b1;
      end
    end
  end

  assign sel_addr    = addr[sel_slot];
  assign sel_data    = data[sel_slot];
  assign sel_nt      = (kind[sel_slot] == K_NT);
  assign sel_is_head = (sel_slot == head);

endmodule

// File: rtl/sb_load_query.sv
module sb_load_query
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] live,
  input  logic [DEPTH-1:0] done,
  input  sb_kind_e         kind [DEPTH],
  input  logic [AW-1:0]    addr [DEPTH],
  input  logic [DW-1:0]    data [DEPTH],
  input  logic [AW-1:0]    q_addr,
  output logic             q_grant,
  output logic             q_hit,
  output logic [DW-1:0]    q_data
);

  logic [IW-1:0] age_slot [DEPTH];

  // Oldest to youngest: a later match overrides, a full fence cuts off
  // every older match.
  always_comb begin
    q_grant = 1'b1;
    q_hit   = 1'b0;
    q_data  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      age_slot[k] = head + IW'(k);
      if (live[age_slot[k]] && !done[age_slot[k]]) begin
        if (kind[age_slot[k]] == K_FULL) begin
          q_grant = 1'b0;
          q_hit   = 1'b0;
          q_data  = '0;
        end else if (kind[age_slot[k]] == K_ST && addr[age_slot[k]] == q_addr) begin
          q_hit  = 1'b1;
          q_data = data[age_slot[k]];
        end
      end
    end
  end

endmodule

// File: rtl/store_fence_buffer.sv
module store_fence_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [1:0]    alloc_kind,
  input  logic [AW-1:0] alloc_addr,
  input  logic [DW-1:0] alloc_data,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_tag,
  input  logic          retire_valid,
  input  logic [IW-1:0] retire_tag,
  input  logic          flush,
  output logic          cm_valid,
  input  logic          cm_ready,
  output logic [IW-1:0] cm_tag,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data,
  output logic          cm_nt,
  input  logic [AW-1:0] lq_addr,
  output logic          lq_grant,
  output logic          lq_hit,
  output logic [DW-1:0] lq_data
);

  logic [IW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic [DEPTH-1:0] ent_live, ent_ret, ent_done;
  sb_kind_e         ent_kind [DEPTH];
  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];

  logic push, cm_fire, sel_is_head, done_set;
  // Named events for the checker
  logic pop_evt, pop_fence, head_store_ready;

  assign alloc_ready = (count != CW'(DEPTH)) && !flush;
  assign alloc_tag   = tail;
  assign push        = alloc_valid && alloc_ready;

  assign cm_fire  = cm_valid && cm_ready;
  assign done_set = cm_fire && !sel_is_head;

  assign pop_fence = ent_live[head] && !ent_done[head] && ent_ret[head] &&
                     is_fence(ent_kind[head]);
  assign pop_evt   = ent_live[head] &&
                     (ent_done[head] || pop_fence || (cm_fire && sel_is_head));
  assign head_store_ready = ent_live[head] && !ent_done[head] && ent_ret[head] &&
                            ent_kind[head] == K_ST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head + IW'(pop_evt);
      tail  <= tail + IW'(push);
      count <= count + CW'(push) - CW'(pop_evt);
    end
  end

  sb_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_entries (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_slot (tail),
    .push_kind (sb_kind_e'(alloc_kind)),
    .push_addr (alloc_addr),
    .push_data (alloc_data),
    .ret_valid (retire_valid),
    .ret_slot  (retire_tag),
    .flush     (flush),
    .done_set  (done_set),
    .done_slot (cm_tag),
    .pop       (pop_evt),
    .pop_slot  (head),
    .live      (ent_live),
    .retired   (ent_ret),
    .done      (ent_done),
    .kind      (ent_kind),
    .addr      (ent_addr),
    .data      (ent_data)
  );

  sb_commit_sel #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sel (
    .head        (head),
    .live        (ent_live),
    .retired     (ent_ret),
    .done        (ent_done),
    .kind        (ent_kind),
    .addr        (ent_addr),
    .data        (ent_data),
    .sel_valid   (cm_valid),
    .sel_slot    (cm_tag),
    .sel_addr    (cm_addr),
    .sel_data    (cm_data),
    .sel_nt      (cm_nt),
    .sel_is_head (sel_is_head)
  );

  sb_load_query #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lq (
    .head    (head),
    .live    (ent_live),
    .done    (ent_done),
    .kind    (ent_kind),
    .addr    (ent_addr),
    .data    (ent_data),
    .q_addr  (lq_addr),
    .q_grant (lq_grant),
    .q_hit   (lq_hit),
    .q_data  (lq_data)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [1:0]    alloc_kind,
  input logic [IW-1:0] alloc_tag,
  input logic          retire_valid,
  input logic [IW-1:0] retire_tag,
  input logic          cm_valid,
  input logic          cm_ready,
  input logic [IW-1:0] cm_tag,
  input logic          lq_grant,
  input logic          pop_evt,
  input logic          pop_fence,
  input logic          head_store_ready
);

  logic [CW-1:0]    sh_cnt;
  logic [DEPTH-1:0] sh_ret;
  logic             acc;

  assign acc = alloc_valid && alloc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_cnt <= '0;
      sh_ret <= '0;
    end else begin
      sh_cnt <= sh_cnt + CW'(acc) - CW'(pop_evt);
      for (int i = 0; i < DEPTH; i++) begin
        if (acc && alloc_tag == IW'(i)) sh_ret[i] <= 1'b0;
        else if (retire_valid && retire_tag == IW'(i)) sh_ret[i] <= 1'b1;
      end
    end
  end

  a_r1_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_cnt == CW'(DEPTH)) |-> !alloc_ready);

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sh_cnt <= CW'(DEPTH));

  a_r2_commit_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_ready) |-> sh_ret[cm_tag]);

  a_r3_head_drains: assert property (@(posedge clk) disable iff (!rst_n)
    head_store_ready |-> cm_valid);

  a_r4_fence_gates_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && alloc_kind == 2'b10) |=> !lq_grant);

  a_r8_fence_pop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fence |-> !(cm_valid && cm_ready));

endmodule

bind store_fence_buffer sb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .alloc_valid      (alloc_valid),
  .alloc_ready      (alloc_ready),
  .alloc_kind       (alloc_kind),
  .alloc_tag        (alloc_tag),
  .retire_valid     (retire_valid),
  .retire_tag       (retire_tag),
  .cm_valid         (cm_valid),
  .cm_ready         (cm_ready),
  .cm_tag           (cm_tag),
  .lq_grant         (lq_grant),
  .pop_evt          (pop_evt),
  .pop_fence        (pop_fence),
  .head_store_ready (head_store_ready)
);

// File: tb/store_fence_buffer_tb.sv
module store_fence_buffer_tb;

  localparam logic [1:0] KS = 2'b00, KN = 2'b01, KF = 2'b10, KSF = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [1:0]  alloc_kind = '0;
  logic [15:0] alloc_addr = '0;
  logic [31:0] alloc_data = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        retire_valid = 1'b0;
  logic [2:0]  retire_tag = '0;
  logic        flush = 1'b0;
  logic        cm_valid;
  logic        cm_ready = 1'b0;
  logic [2:0]  cm_tag;
  logic [15:0] cm_addr;
  logic [31:0] cm_data;
  logic        cm_nt;
  logic [15:0] lq_addr = '0;
  logic        lq_grant;
  logic        lq_hit;
  logic [31:0] lq_data;

  always #2 clk = ~clk;

  store_fence_buffer u_dut (.*);

  typedef struct {
    logic [15:0] a;
    logic [31:0] d;
    logic        nt;
  } exp_t;

  exp_t sbq[$];
  int   n_checks = 0;
  int   n_err = 0;
  bit   finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_commit(input logic [15:0] a, input logic [31:0] d, input logic nt);
    exp_t e;
    e.a = a; e.d = d; e.nt = nt;
    sbq.push_back(e);
  endtask

  // Scoreboard monitor: one write per cycle when valid and ready meet
  always @(negedge clk) begin
    if (rst_n && cm_valid && cm_ready) begin
      n_checks++;
      if (sbq.size() == 0) begin
        n_err++;
        $display("FAIL R3 unexpected write actual=%0h/%0h expected=none", cm_addr, cm_data);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (cm_addr !== e.a || cm_data !== e.d || cm_nt !== e.nt) begin
          n_err++;
          $display("FAIL R3 write order actual=%0h/%0h/%0b expected=%0h/%0h/%0b",
                   cm_addr, cm_data, cm_nt, e.a, e.d, e.nt);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_alloc(input logic [1:0] k, input logic [15:0] a, input logic [31:0] d,
                          output logic [2:0] t);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_kind = k; alloc_addr = a; alloc_data = d;
    while (!alloc_ready) @(negedge clk);
    t = alloc_tag;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_retire(input logic [2:0] t);
    retire_valid = 1'b1; retire_tag = t;
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] t0, t1, t2, t3;
    logic [2:0] tg [8];

    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    chk("R11 ready", alloc_ready, 1);
    chk("R11 cm_valid", cm_valid, 0);
    chk("R11 grant", lq_grant, 1);
    chk("R11 hit", lq_hit, 0);

    // R2/R3: nothing leaves before retire, then stores drain in order
    cm_ready = 1'b1;
    do_alloc(KS, 16'h0010, 32'hA1, t0);
    idle(2);
    chk("R2 no write before retire", cm_valid, 0);
    do_alloc(KS, 16'h0014, 32'hA2, t1);
    do_alloc(KS, 16'h0018, 32'hA3, t2);
    expect_commit(16'h0010, 32'hA1, 0);
    expect_commit(16'h0014, 32'hA2, 0);
    expect_commit(16'h0018, 32'hA3, 0);
    @(negedge clk);
    do_retire(t0);
    chk("R2 offered after retire", {cm_valid, cm_addr}, {1'b1, 16'h0010});
    do_retire(t1);
    do_retire(t2);
    idle(6);
    chk("R3 all drained", sbq.size(), 0);

    // R1: full queue refuses and a held request is not taken
    cm_ready = 1'b0;
    for (int i = 0; i < 8; i++) do_alloc(KS, 16'h0100 + 16'(i * 4), 32'hB0 + i, tg[i]);
    chk("R1 full", alloc_ready, 0);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_kind = KS; alloc_addr = 16'h0200; alloc_data = 32'hCC;
    idle(3);
    chk("R1 held not ready", alloc_ready, 0);
    alloc_valid = 1'b0;
    lq_addr = 16'h0200;
    idle(1);
    chk("R1 held not entered", lq_hit, 0);
    for (int i = 0; i < 8; i++) begin
      expect_commit(16'h0100 + 16'(i * 4), 32'hB0 + i, 0);
      do_retire(tg[i]);
    end
    cm_ready = 1'b1;
    idle(12);
    chk("R1 ready after drain", alloc_ready, 1);
    chk("R3 full drained", sbq.size(), 0);

    // R9/R7/R4: forwarding and full fence
    cm_ready = 1'b0;
    do_alloc(KS, 16'h0040, 32'hD1, t0);
    do_alloc(KS, 16'h0040, 32'hD2, t1);
    lq_addr = 16'h0040;
    idle(1);
    chk("R9 youngest match", {lq_hit, lq_data}, {1'b1, 32'hD2});
    chk("R7 stores do not block loads", lq_grant, 1);
    lq_addr = 16'h0044;
    idle(1);
    chk("R9 miss", lq_hit, 0);
    do_alloc(KF, 16'h0, 32'h0, t2);
    lq_addr = 16'h0040;
    idle(1);
    chk("R4 fence blocks load", lq_grant, 0);
    chk("R9 fence cuts forward", lq_hit, 0);
    do_alloc(KS, 16'h0040, 32'hD3, t3);
    idle(1);
    chk("R9 forward after fence", {lq_hit, lq_data}, {1'b1, 32'hD3});
    expect_commit(16'h0040, 32'hD1, 0);
    expect_commit(16'h0040, 32'hD2, 0);
    expect_commit(16'h0040, 32'hD3, 0);
    do_retire(t0); do_retire(t1); do_retire(t2); do_retire(t3);
    chk("R4 retired fence not at head", lq_grant, 0);
    cm_ready = 1'b1;
    idle(8);
    chk("R4 grant after fence gone", lq_grant, 1);
    chk("R3 fence drained", sbq.size(), 0);

    // R8: lone fence leaves in one cycle, no write
    do_alloc(KF, 16'h0, 32'h0, t0);
    @(negedge clk);
    do_retire(t0);
    chk("R8 fence still present", lq_grant, 0);
    idle(1);
    chk("R8 fence gone next cycle", lq_grant, 1);

    // R6: NT overtakes a speculative regular store
    do_alloc(KS, 16'h0060, 32'hE1, t0);
    do_alloc(KN, 16'h0064, 32'hE2, t1);
    lq_addr = 16'h0064;
    idle(1);
    chk("R9 NT never forwards", lq_hit, 0);
    expect_commit(16'h0064, 32'hE2, 1);
    do_retire(t1);
    chk("R6 NT offered first", {cm_valid, cm_nt, cm_addr}, {2'b11, 16'h0064});
    idle(3);
    expect_commit(16'h0060, 32'hE1, 0);
    do_retire(t0);
    idle(4);
    chk("R6 drained", sbq.size(), 0);

    // R5/R7: store fence holds the NT store back
    do_alloc(KS, 16'h0070, 32'hF1, t0);
    do_alloc(KSF, 16'h0, 32'h0, t1);
    do_alloc(KN, 16'h0074, 32'hF2, t2);
    idle(1);
    chk("R7 store fence leaves grant", lq_grant, 1);
    do_retire(t2);
    do_retire(t1);
    idle(3);
    chk("R5 NT held behind store fence", cm_valid, 0);
    expect_commit(16'h0070, 32'hF1, 0);
    expect_commit(16'h0074, 32'hF2, 1);
    do_retire(t0);
    idle(6);
    chk("R5 drained", sbq.size(), 0);

    // R10: flush kills speculative entries, retired fence stays
    cm_ready = 1'b0;
    do_alloc(KS, 16'h0080, 32'h61, t0);
    @(negedge clk);
    do_retire(t0);
    do_alloc(KF, 16'h0, 32'h0, t1);
    @(negedge clk);
    do_retire(t1);
    do_alloc(KS, 16'h0084, 32'h62, t2);
    do_alloc(KF, 16'h0, 32'h0, t3);
    flush = 1'b1;
    idle(0);
    #1;
    chk("R10 no alloc during flush", alloc_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    lq_addr = 16'h0084;
    idle(1);
    chk("R10 retired fence kept", lq_grant, 0);
    chk("R10 killed store not forwarded", lq_hit, 0);
    expect_commit(16'h0080, 32'h61, 0);
    cm_ready = 1'b1;
    idle(10);
    chk("R10 grant after drain", lq_grant, 1);
    chk("R10 slots freed", alloc_ready, 1);
    chk("R10 only retired store written", sbq.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule